// File: doc/BRIEF.md
# Line-Synchronous Pixel Clock Divider

The block produces a pixel clock for a scanning print engine by dividing a fast oscillator clock by an even ratio, which a 3-bit resolution code selects. A separate synchronizer, which sits outside this block, turns each beam-detect event into a one-cycle restart strobe in the fast clock domain. The divider samples the resolution code only on that strobe. This means the ratio can change from one scan line to the next, and it stays fixed while a line is being imaged.

On every restart the divider drops its current phase and starts a new period. The new period is a low half followed by a high half, each lasting ratio/2 fast clocks. The output comes straight from a flip-flop, so it changes only on rising edges of the fast clock and has no combinational glitches.

Top module: `line_pixclk_div`

## Requirements
- R1: While `rst_n` is low, `pix_clk` is 0. After reset the active ratio is ÷8 (code 3'b111). The first rising edge of `pix_clk` follows the 4th rising edge of `clk_fast` after reset is released.
- R2: The codes map to ratios as follows: 3'b101 ÷2, 3'b110 ÷4, 3'b111 ÷8, 3'b000 ÷16, 3'b001 ÷32, 3'b010 ÷64, 3'b011 ÷128, 3'b100 ÷256.
- R3: `res_code` is sampled only on a `clk_fast` edge where `line_restart` is 1. Changes to `res_code` at any other time leave the running ratio unchanged.
- R4: After a `clk_fast` edge with `line_restart` high, `pix_clk` is 0 and a new period begins. This holds even when the strobe arrives in the middle of a high phase.
- R5: Between restarts, `pix_clk` alternates a low phase and a high phase. Each phase lasts exactly ratio/2 `clk_fast` cycles, so the period is `ratio` fast clocks with a 50/50 duty cycle.
- R6: The first rising edge of `pix_clk` after a restart comes ratio/2 `clk_fast` edges after the strobe edge, which is half an output period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_code | input | 3 | Resolution code selecting the divide ratio |
| line_restart | input | 1 | One-cycle strobe marking a line start (synchronized beam detect) |
| pix_clk | output | 1 | Divided pixel clock, driven from a register |

## Verification
A wrong active code or a bad terminal count shows at the output as a wrong phase length. A check that compares every cycle against the ideal square wave therefore catches it within the first half period after a restart. A capture that fires at the wrong time only shows once `res_code` moves in the middle of a line. For that reason the bench changes the code right after a strobe and watches the next several periods. A faulty restart path shows on the cycle right after the strobe, as a high output or as a first rising edge at the wrong cycle.

// File: rtl/line_pixclk_div.sv
module line_pixclk_div #(
  parameter int CODE_W = 3,
  parameter int CNT_W  = 8
) (
  input  logic              clk_fast,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] res_code,
  input  logic              line_restart,
  output logic              pix_clk
);
  localparam logic [CODE_W-1:0] DEF_CODE = '1;

  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  half_m1;

  always_comb begin
    case (code_q)
      3'd0:    half_m1 = CNT_W'(7);
      3'd1:    half_m1 = CNT_W'(15);
      3'd2:    half_m1 = CNT_W'(31);
      3'd3:    half_m1 = CNT_W'(63);
      3'd4:    half_m1 = CNT_W'(127);
      3'd5:    half_m1 = CNT_W'(0);
      3'd6:    half_m1 = CNT_W'(1);
      default: half_m1 = CNT_W'(3);
    endcase
  end

  wire last = (cnt_q == half_m1);

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= DEF_CODE;
      cnt_q   <= '0;
      pix_clk <= 1'b0;
    end else if (line_restart) begin
      code_q  <= res_code;
      cnt_q   <= '0;
      pix_clk <= 1'b0;
    end else begin
      cnt_q   <= last ? '0 : cnt_q + 1'b1;
      pix_clk <= last ? ~pix_clk : pix_clk;
    end
  end
endmodule

// File: rtl/line_pixclk_div_chk.sv
module line_pixclk_div_chk (
  input logic       clk_fast,
  input logic       rst_n,
  input logic [2:0] res_code,
  input logic       line_restart,
  input logic       pix_clk,
  input logic [2:0] code_q,
  input logic [7:0] cnt_q
);
  function automatic logic [8:0] half_of(input logic [2:0] c);
    return (c > 3'd4) ? 9'(1) << (c - 3'd5) : 9'(8) << c;
  endfunction

  wire [8:0] chk_half = half_of(code_q);

  AST_RESTART_LOW: assert property (@(posedge clk_fast) disable iff (!rst_n)
    line_restart |=> (!pix_clk && cnt_q == 8'd0)); // R4
  AST_CODE_CAPTURE: assert property (@(posedge clk_fast) disable iff (!rst_n)
    line_restart |=> (code_q == $past(res_code))); // R3
  AST_CODE_HOLD: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !line_restart |=> $stable(code_q)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk_fast) disable iff (!rst_n)
    ({1'b0, cnt_q} < chk_half)); // R5
  AST_PHASE_HOLD: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (!line_restart && ({1'b0, cnt_q} + 9'd1 != chk_half)) |=> $stable(pix_clk)); // R5
endmodule

bind line_pixclk_div line_pixclk_div_chk u_chk (
  .clk_fast(clk_fast), .rst_n(rst_n), .res_code(res_code),
  .line_restart(line_restart), .pix_clk(pix_clk),
  .code_q(code_q), .cnt_q(cnt_q)
);

// File: tb/sim_line_pixclk_div.sv
`timescale 1ns/1ps
module sim_line_pixclk_div;
  logic       clk_fast = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] res_code = 3'b111;
  logic       line_restart = 1'b0;
  logic       pix_clk;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk_fast = ~clk_fast;

  line_pixclk_div u0 (.clk_fast(clk_fast), .rst_n(rst_n), .res_code(res_code),
                      .line_restart(line_restart), .pix_clk(pix_clk));

  // code, expected half period (R2)
  localparam int NV = 8;
  localparam logic [11:0] VEC [NV] = '{
    {3'b101, 9'd1},   {3'b110, 9'd2},  {3'b111, 9'd4},  {3'b000, 9'd8},
    {3'b001, 9'd16},  {3'b010, 9'd32}, {3'b011, 9'd64}, {3'b100, 9'd128}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restart(input logic [2:0] c);
    @(negedge clk_fast);
    res_code = c;
    line_restart = 1'b1;
    @(negedge clk_fast);
    line_restart = 1'b0;
  endtask

  // called at the negedge after edge k0 counted from the reference edge
  task automatic wave(input int half, input int k0, input int n, input string req);
    int bad = -1;
    int got = 0;
    for (int k = k0; k < k0 + n; k++) begin
      if (bad < 0 && pix_clk !== 1'((k / half) % 2)) begin
        bad = k;
        got = pix_clk;
      end
      if (k < k0 + n - 1) @(negedge clk_fast);
    end
    check(bad < 0, req, got, (bad < 0) ? 0 : (bad / half) % 2);
  endtask

  initial begin
    repeat (3) @(negedge clk_fast);
    check(pix_clk === 1'b0, "R1 reset low", pix_clk, 0);
    rst_n = 1'b1;
    @(negedge clk_fast);
    wave(4, 1, 24, "R1 default div8");

    for (int i = 0; i < NV; i++) begin
      restart(VEC[i][11:9]);
      wave(int'(VEC[i][8:0]), 0, 4 * int'(VEC[i][8:0]), "R2 R5 R6 ratio table");
    end

    restart(3'b101);
    res_code = 3'b100;
    wave(1, 0, 20, "R3 mid-line code ignored");

    restart(3'b111);
    wave(4, 0, 6, "R6 first rise at half period");
    check(pix_clk === 1'b1, "R4 high before restart", pix_clk, 1);
    restart(3'b110);
    check(pix_clk === 1'b0, "R4 forced low", pix_clk, 0);
    wave(2, 0, 12, "R4 R5 new period after restart");

    restart(3'b000);
    restart(3'b000);
    wave(8, 0, 32, "R4 back-to-back restart");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule